// File: doc/BRIEF.md
# Mutation-Based Scan Test Decompressor

This block drives a bank of 2^SEL_W scan chains from a narrow test-data interface: one serial request bit, an enable and a SEL_W-bit chain index. It does not shift a fresh pattern into the chains. The chains rotate continuously through the block, and each scan-out bit comes back in at the same chain's scan-in. To build the next pattern, the tester names one chain per shift cycle. The bit leaving that chain in the following cycle is written back inverted. Every other bit comes back unchanged.

A binary-to-one-hot decoder turns the index into a chain select. It is gated by the request bit and the enable, and it is captured in a decoder output register. That register steers a multiplexer in front of each chain. The multiplexer picks either the plain recirculated bit or its inverse. A rotation counter tracks the shift position. After each full chain-length rotation it raises a one-clock strobe, which marks the moment the chains again hold a complete, aligned pattern.

Top module: `scan_mutate_decomp`

## Requirements
- R1: While `rst` is high, the decoder output register is cleared. Every `chain_si` bit equals its `chain_so` bit, and `pattern_done` is low.
- R2: In a cycle with no flip registered from the previous cycle, `chain_si[i]` equals `chain_so[i]` for every chain i.
- R3: A request with `en`=1, `din`=1 and `sel`=s in cycle c makes `chain_si[s]` equal to the inverse of `chain_so[s]` in cycle c+1. The value s is the binary index of the chain, so bit s of both chain buses is affected. No other chain is affected.
- R4: With `en`=0, no chain is inverted in the next cycle, whatever the values of `din` and `sel`. A held pattern survives a full rotation unchanged.
- R5: With `en`=1 and `din`=0, no chain is inverted in the next cycle.
- R6: In any cycle, at most one chain has `chain_si` differing from `chain_so`.
- R7: An inversion lasts exactly one cycle unless it is requested again. Isolated requests flip single bits, including at the last shift position before a rotation ends.
- R8: `pattern_done` is high for exactly one clock after every CHAIN_LEN-th rising edge following reset release, and low otherwise.
- R9: At each `pattern_done`, every chain holds its previous pattern with exactly the requested bit positions inverted. Inverting the same position twice restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; chains shift on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows requests to reach the decoder output register |
| din | input | 1 | Serial request bit: 1 asks for an inversion this cycle |
| sel | input | SEL_W | Binary index of the chain to invert |
| chain_so | input | 2^SEL_W | Scan-out bit of each chain |
| chain_si | output | 2^SEL_W | Scan-in bit of each chain: recirculated or inverted |
| pattern_done | output | 1 | One-clock strobe after each full rotation |

## Verification
The assertions assume that the chains outside the block shift on every clock once reset is released. They also assume that `sel`, `din` and `en` are stable around the rising edge, so that each registered request belongs to a single cycle. The stimulus meets this by updating all three inputs once per cycle, well after the edge. It drives every cycle from reset release onward. The bench's own chain model shifts on each edge outside reset, which keeps the shift positions aligned with the rotation counter.

// File: rtl/scan_mut_pkg.sv
package scan_mut_pkg;

    // How a lane treats the bit that comes back from its chain.
    typedef enum logic {
        LANE_PASS   = 1'b0,
        LANE_INVERT = 1'b1
    } lane_mode_e;

    // Phase of the rotation as seen by the counter.
    typedef enum logic {
        ROT_MID  = 1'b0,
        ROT_WRAP = 1'b1
    } rot_phase_e;

    function automatic logic lane_drive(input lane_mode_e mode, input logic bit_in);
        return (mode == LANE_INVERT) ? ~bit_in : bit_in;
    endfunction

    function automatic lane_mode_e mode_of(input logic pick);
        return pick ? LANE_INVERT : LANE_PASS;
    endfunction

endpackage

// File: rtl/scan_mut_decoder.sv
module scan_mut_decoder #(
    parameter int SEL_W = 3
) (
    input  logic                  fire,
    input  logic [SEL_W-1:0]      idx,
    output logic [(1<<SEL_W)-1:0] hot
);
    localparam int NOUT = 1 << SEL_W;

    // One comparator per output; only a fired request raises a line.
    for (genvar j = 0; j < NOUT; j++) begin : g_line
        assign hot[j] = fire && (idx == SEL_W'(j));
    end
endmodule

// File: rtl/scan_mut_dor.sv
module scan_mut_dor #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hot_in,
    output logic [WIDTH-1:0] pick_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= '0;
        end else begin
            pick_q <= hot_in;
        end
    end

    AST_PICK_CLEARED: assert property (@(posedge clk) rst |=> (pick_q == '0)); // R1
    AST_PICK_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0(pick_q)); // R6
endmodule

// File: rtl/scan_mut_lane.sv
module scan_mut_lane
    import scan_mut_pkg::*;
(
    input  logic pick,
    input  logic from_chain,
    output logic to_chain
);
    lane_mode_e mode;

    always_comb begin
        mode     = mode_of(pick);
        to_chain = lane_drive(mode, from_chain);
    end
endmodule

// File: rtl/scan_mut_rotation.sv
module scan_mut_rotation
    import scan_mut_pkg::*;
#(
    parameter int CHAIN_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    output logic done_q
);
    localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CHAIN_LEN - 1);

    logic [CNT_W-1:0] pos_q;
    rot_phase_e       phase;

    always_comb begin
        phase = (pos_q == LAST_POS) ? ROT_WRAP : ROT_MID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            done_q <= 1'b0;
        end else if (phase == ROT_WRAP) begin
            pos_q  <= '0;
            done_q <= 1'b1;
        end else begin
            pos_q  <= pos_q + 1'b1;
            done_q <= 1'b0;
        end
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q); // R8
    AST_DONE_AT_START:  assert property (@(posedge clk) disable iff (rst) done_q |-> (pos_q == '0)); // R8
endmodule

// File: rtl/scan_mutate_decomp.sv
module scan_mutate_decomp #(
    parameter int SEL_W     = 3,
    parameter int CHAIN_LEN = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  din,
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] chain_so,
    output logic [(1<<SEL_W)-1:0] chain_si,
    output logic                  pattern_done
);
    localparam int NCH = 1 << SEL_W;

    logic           req_fire;
    logic [NCH-1:0] hot;
    logic [NCH-1:0] pick_q;

    assign req_fire = en & din;

    scan_mut_decoder #(.SEL_W(SEL_W)) u_dec (
        .fire (req_fire),
        .idx  (sel),
        .hot  (hot)
    );

    scan_mut_dor #(.WIDTH(NCH)) u_dor (
        .clk    (clk),
        .rst    (rst),
        .hot_in (hot),
        .pick_q (pick_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        scan_mut_lane u_lane (
            .pick       (pick_q[i]),
            .from_chain (chain_so[i]),
            .to_chain   (chain_si[i])
        );
    end

    scan_mut_rotation #(.CHAIN_LEN(CHAIN_LEN)) u_rot (
        .clk    (clk),
        .rst    (rst),
        .done_q (pattern_done)
    );

    AST_EN_LOW_NO_FLIP:  assert property (@(posedge clk) disable iff (rst) !en |=> (chain_si == chain_so)); // R4
    AST_DIN_LOW_NO_FLIP: assert property (@(posedge clk) disable iff (rst) !din |=> (chain_si == chain_so)); // R5
    AST_SEL_HITS_CHAIN:  assert property (@(posedge clk) disable iff (rst)
        (en && din) |=> ((chain_si ^ chain_so) == (NCH'(1) << $past(sel)))); // R3
    AST_SINGLE_CYCLE:    assert property (@(posedge clk) disable iff (rst)
        (pick_q != '0) && !(en && din) |=> (chain_si == chain_so)); // R7
endmodule

// File: tb/sim_scan_mutate_decomp.sv
module sim_scan_mutate_decomp;
    localparam int SEL_W = 3;
    localparam int NCH   = 1 << SEL_W;
    localparam int LEN   = 16;

    typedef struct {
        logic [NCH-1:0] vec;
        string          tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, din = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic [NCH-1:0] chain_so, chain_si;
    logic pattern_done;

    int errors = 0, checks = 0;
    int n = 0;
    bit run = 0, finished = 0;
    exp_t q[$];

    logic [LEN-1:0] chain  [NCH];
    logic [LEN-1:0] golden [NCH];

    always #10 clk = ~clk;

    scan_mutate_decomp #(.SEL_W(SEL_W), .CHAIN_LEN(LEN)) u0 (
        .clk(clk), .rst(rst), .en(en), .din(din), .sel(sel),
        .chain_so(chain_so), .chain_si(chain_si), .pattern_done(pattern_done)
    );

    function automatic logic [LEN-1:0] init_pat(input int i);
        return LEN'(16'hA5C3 ^ (i * 16'h1357));
    endfunction

    // External scan chains: shift every clock once out of reset.
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst) chain[i] <= init_pat(i);
            else     chain[i] <= {chain_si[i], chain[i][LEN-1:1]};
        end
    end
    always_comb for (int i = 0; i < NCH; i++) chain_so[i] = chain[i][0];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at n=%0d", req, act, expv, n);
        end
    endtask

    // Monitor: pops the flip vector that is being applied in this cycle.
    always @(negedge clk) begin
        if (rst) begin
            check(chain_si == chain_so, "R1", 64'(chain_si), 64'(chain_so));
            check(pattern_done == 1'b0, "R1", 64'(pattern_done), 64'd0);
        end else if (run && q.size() == 2) begin
            exp_t e;
            bit   exp_done;
            e = q.pop_front();
            exp_done = (n > 0) && (n % LEN == 0);
            check(pattern_done == exp_done, "R8", 64'(pattern_done), 64'(exp_done));
            if (exp_done)
                for (int i = 0; i < NCH; i++)
                    check(chain[i] == golden[i], "R9", 64'(chain[i]), 64'(golden[i]));
            check($countones(chain_si ^ chain_so) <= 1, "R6", 64'(chain_si ^ chain_so), 64'd0);
            check(chain_si == (chain_so ^ e.vec), (e.vec == '0) ? {e.tag, "/R2"} : e.tag,
                  64'(chain_si), 64'(chain_so ^ e.vec));
            for (int i = 0; i < NCH; i++) golden[i][n % LEN] ^= e.vec[i];
            n++;
        end
    end

    // Driver: applies one request per cycle and pushes what it should cause.
    task automatic cyc(input logic e_in, input logic d_in, input int s_in, input string tag);
        exp_t item;
        en  = e_in;
        din = d_in;
        sel = SEL_W'(s_in);
        item.vec = (e_in && d_in) ? (NCH'(1) << s_in) : '0;
        item.tag = tag;
        q.push_back(item);
        @(posedge clk);
        #5;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) golden[i] = init_pat(i);
        repeat (3) @(posedge clk);
        #5;
        rst = 1'b0;
        q.push_back('{vec: '0, tag: "R1"});
        run = 1;
        // R4: enable low, din and sel busy; pattern must survive two rotations
        for (int k = 0; k < 2 * LEN; k++) cyc(1'b0, 1'b1, k % NCH, "R4");
        // R5: enabled but no request bit
        for (int k = 0; k < LEN; k++) cyc(1'b1, 1'b0, (k * 5) % NCH, "R5");
        // R3: one flip every cycle, walking over chains
        for (int k = 0; k < 2 * LEN; k++) cyc(1'b1, 1'b1, (k * 3) % NCH, "R3");
        // R9: same sequence at the same positions undoes it
        for (int k = 0; k < 2 * LEN; k++) cyc(1'b1, 1'b1, (k * 3) % NCH, "R9");
        // R7: isolated flips on the edge chains, including the wrap position
        for (int k = 0; k < 3 * LEN; k++)
            cyc(1'b1, (k % 5 == 0) || (k % LEN == LEN - 2), (k % 2) ? NCH - 1 : 0, "R7");
        // R3: back-to-back flips on one chain
        for (int k = 0; k < LEN; k++) cyc(1'b1, (k < 4), 5, "R3");
        // idle rotation so the last flips reach a done check
        for (int k = 0; k < LEN + 1; k++) cyc(1'b1, 1'b0, 0, "R2");
        run = 0;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule